// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a set of general-purpose external input pins and one extra non-maskable pin. It turns activity on them into interrupt requests and event pulses. Each pin is first brought into the local clock domain. It can then pass through a three-sample majority-vote filter. After that it is tested against a per-line sense condition: rising edge, falling edge, either edge, high level or low level. Lines whose condition fires set a sticky flag. Unmasked general flags are OR-ed into one maskable request. The dedicated line drives its own non-maskable request output.

Software programs the block over a small single-cycle register port. The sense, filter, event-enable and related configuration fields are locked while the controller runs. Each general line can be owned by the secure side. Accesses that are marked non-secure then see that line's bits as zero, and their writes to those bits are dropped. A self-clearing wipe bit in the control word puts every register back to its reset value.

Top module: `xint_ctrl`

## Requirements
- R1: The dedicated line has its own sense field in the word at address 0x1 (bits 2:0 sense, bit 3 filter). Its flag is bit 8 of the flag word. It drives `nmi_req_o` whenever that flag is set, with no mask. Writing 1 to bit 8 clears it.
- R2: The sense codes are 0 = off, 1 = rising, 2 = falling, 3 = both edges, 4 = high level, 5 = low level. Codes 6 and 7 also mean off. Line i uses bits 4i+2..4i of the word at address 0x5, and bit 4i+3 of that word turns on its filter. A line that is set to off never sets its flag.
- R3: A line whose condition fires sets its bit in the flag word (0x3), whether or not it is masked. `irq_o` is high exactly when some flag bit is set and the matching bit of the mask word (0x2) is also set.
- R4: When a line's filter is on, a pin pulse that lasts one clock is rejected. A pulse that lasts two or more clocks is accepted. Each pin goes through a two-flop synchronizer, so a flag appears within six clocks of the pin change.
- R5: `evt_o[i]` pulses for one clock for each detection on line i, but only if bit i of the event-enable word (0x4) is set. A both-edge line gives two pulses for one high pulse on its pin.
- R6: Flags are cleared by writing 1 to them. In a level mode the flag is set again on every clock that the level stays active, so a clear has no effect until the level goes away.
- R7: The words at 0x4, 0x5, 0x6, 0x7 and 0x8 accept writes only while the run bit (bit 0 of 0x0) is 0. At other times the write is ignored and the stored value stays the same.
- R8: The clock-select bit (bit 2 of 0x0) follows a control write only when the run bit was 0 before that write. So it can be set in the same write that starts the controller, but it stays unchanged in a write that stops it.
- R9: Writing 1 to bit 1 of 0x0 returns every register and flag to zero. This leaves the controller stopped.
- R10: A 1 in bit i of the ownership word (0x9) makes line i secure. For an access with `bus_nonsec` high, that line's bits read as 0 and writes to them are dropped. The ownership word itself ignores non-secure writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NLINES | General external pins |
| nmi_pin_i | input | 1 | Dedicated non-maskable pin |
| bus_wr | input | 1 | Write strobe, one clock |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_nonsec | input | 1 | Access is non-secure |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Combined maskable request |
| nmi_req_o | output | 1 | Non-maskable request |
| evt_o | output | NLINES | Per-line event pulses |

## Verification
The assertions check on every cycle the rules that span one clock. Locked configuration and the clock-select bit stay stable while running. A wipe leaves the controller stopped. A detection always lands in the flag, and flags persist unless cleared. Events appear only on enabled lines, and non-secure writes cannot change the ownership word. Other behaviour can only be shown by the bench's scenarios. This covers spike rejection against acceptance, the two pulses from a both-edge line, a level flag that survives a clear, the read masking that hides secure lines, and the full register picture after a wipe.

// File: rtl/xint_pkg.sv
// Shared constants for the external interrupt line controller.
// Assumes a 4-bit word address and 32-bit data on the register port.
package xint_pkg;
    typedef enum logic [2:0] {
        SNS_OFF  = 3'd0,
        SNS_RISE = 3'd1,
        SNS_FALL = 3'd2,
        SNS_BOTH = 3'd3,
        SNS_HIGH = 3'd4,
        SNS_LOW  = 3'd5
    } sense_e;

    localparam logic [3:0] A_CTRL   = 4'h0;
    localparam logic [3:0] A_NMICFG = 4'h1;
    localparam logic [3:0] A_MASK   = 4'h2;
    localparam logic [3:0] A_FLAG   = 4'h3;
    localparam logic [3:0] A_EVEN   = 4'h4;
    localparam logic [3:0] A_SENSE  = 4'h5;
    localparam logic [3:0] A_ASYNC  = 4'h6;
    localparam logic [3:0] A_DBEN   = 4'h7;
    localparam logic [3:0] A_DBPRE  = 4'h8;
    localparam logic [3:0] A_OWNER  = 4'h9;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_WIPE  = 1;
    localparam int CTRL_CKSEL = 2;
    localparam int CFG_BITS   = 4;
endpackage

// File: rtl/xint_cond.sv
// One input line: two-flop synchronizer, optional three-sample majority
// filter, and sense-condition detection.
// Assumes pin_i is asynchronous and that the configuration is quasi-static.
module xint_cond
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       run_i,
    input  logic [2:0] sense_i,
    input  logic       filt_i,
    output logic       hit_o
);
    localparam int HIST = 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST-1:0]        hist_q;
    logic                   smp;
    logic                   maj;
    logic                   val;
    logic                   prev_q;

    assign smp = sync_q[SYNC_STAGES-1];

    // Synchronizer chain: bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    // Sample history feeding the majority vote.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST-2:0], smp};
    end

    // Majority of current and two earlier samples.
    always_comb begin
        maj = (smp & hist_q[0]) | (smp & hist_q[1]) | (hist_q[0] & hist_q[1]);
        val = filt_i ? maj : smp;
    end

    // Previous filtered value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= val;
    end

    // Sense decode: one condition per mode, gated by run.
    always_comb begin
        unique case (sense_i)
            SNS_RISE: hit_o = val & ~prev_q;
            SNS_FALL: hit_o = ~val & prev_q;
            SNS_BOTH: hit_o = val ^ prev_q;
            SNS_HIGH: hit_o = val;
            SNS_LOW:  hit_o = ~val;
            default:  hit_o = 1'b0;
        endcase
        if (!run_i) hit_o = 1'b0;
    end
endmodule

// File: rtl/xint_regs.sv
// Register file, flags and outputs for the controller.
// Assumes single-cycle writes and combinational reads; the wipe bit acts
// as a synchronous reset of all state. Line NL is the non-maskable line.
module xint_regs
    import xint_pkg::*;
#(
    parameter int NL = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [3:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_nonsec,
    output logic [31:0]           bus_rdata,
    input  logic [NL:0]           hit_i,
    output logic                  run_o,
    output logic [NL*CFG_BITS-1:0] sense_o,
    output logic [CFG_BITS-1:0]   nmicfg_o,
    output logic                  irq_o,
    output logic                  nmi_req_o,
    output logic [NL-1:0]         evt_o
);
    localparam int SW = NL * CFG_BITS;

    logic              run_q, cksel_q;
    logic [CFG_BITS-1:0] nmicfg_q;
    logic [NL-1:0]     mask_q, even_q, async_q, dben_q, owner_q, evt_q;
    logic [7:0]        dbpre_q;
    logic [SW-1:0]     sense_q;
    logic [NL:0]       flag_q;
    logic [NL-1:0]     lmask;
    logic [SW-1:0]     nmask;
    logic              wipe_w;
    logic              wr_open;
    logic [NL:0]       clr_w;

    // Lines visible to this access.
    assign lmask   = bus_nonsec ? ~owner_q : '1;
    assign wipe_w  = bus_wr && bus_addr == A_CTRL && bus_wdata[CTRL_WIPE];
    assign wr_open = bus_wr && !run_q;

    for (genvar g = 0; g < NL; g++) begin : g_nib
        assign nmask[g*CFG_BITS +: CFG_BITS] = {CFG_BITS{lmask[g]}};
    end

    // Write-one-to-clear request, non-secure writes limited to open lines.
    assign clr_w = (bus_wr && bus_addr == A_FLAG)
                   ? (bus_wdata[NL:0] & {1'b1, lmask}) : '0;

    // Control word: run, and clock select only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_w) begin
            run_q   <= 1'b0;
            cksel_q <= 1'b0;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            run_q <= bus_wdata[CTRL_RUN];
            if (!run_q) cksel_q <= bus_wdata[CTRL_CKSEL];
        end
    end

    // Unlocked words: dedicated-line config, mask and ownership.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_w) begin
            nmicfg_q <= '0;
            mask_q   <= '0;
            owner_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_NMICFG) nmicfg_q <= bus_wdata[CFG_BITS-1:0];
            if (bus_addr == A_MASK)
                mask_q <= (mask_q & ~lmask) | (bus_wdata[NL-1:0] & lmask);
            if (bus_addr == A_OWNER && !bus_nonsec) owner_q <= bus_wdata[NL-1:0];
        end
    end

    // Locked words: writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_w) begin
            even_q  <= '0;
            sense_q <= '0;
            async_q <= '0;
            dben_q  <= '0;
            dbpre_q <= '0;
        end else if (wr_open) begin
            unique case (bus_addr)
                A_EVEN:  even_q  <= (even_q & ~lmask) | (bus_wdata[NL-1:0] & lmask);
                A_SENSE: sense_q <= (sense_q & ~nmask) | (bus_wdata[SW-1:0] & nmask);
                A_ASYNC: async_q <= (async_q & ~lmask) | (bus_wdata[NL-1:0] & lmask);
                A_DBEN:  dben_q  <= (dben_q & ~lmask) | (bus_wdata[NL-1:0] & lmask);
                A_DBPRE: dbpre_q <= bus_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Sticky flags: a detection wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_w) flag_q <= '0;
        else                  flag_q <= (flag_q & ~clr_w) | hit_i;
    end

    // Event pulses for enabled lines.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_w) evt_q <= '0;
        else                  evt_q <= hit_i[NL-1:0] & even_q;
    end

    // Read mux with secure lines hidden from non-secure accesses.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   begin
                bus_rdata[CTRL_RUN]   = run_q;
                bus_rdata[CTRL_CKSEL] = cksel_q;
            end
            A_NMICFG: bus_rdata[CFG_BITS-1:0] = nmicfg_q;
            A_MASK:   bus_rdata[NL-1:0] = mask_q & lmask;
            A_FLAG:   bus_rdata[NL:0]   = flag_q & {1'b1, lmask};
            A_EVEN:   bus_rdata[NL-1:0] = even_q & lmask;
            A_SENSE:  bus_rdata[SW-1:0] = sense_q & nmask;
            A_ASYNC:  bus_rdata[NL-1:0] = async_q & lmask;
            A_DBEN:   bus_rdata[NL-1:0] = dben_q & lmask;
            A_DBPRE:  bus_rdata[7:0]    = dbpre_q;
            A_OWNER:  bus_rdata[NL-1:0] = owner_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign run_o     = run_q;
    assign sense_o   = sense_q;
    assign nmicfg_o  = nmicfg_q;
    assign irq_o     = |(flag_q[NL-1:0] & mask_q);
    assign nmi_req_o = flag_q[NL];
    assign evt_o     = evt_q;

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wipe_w) |=> ($stable(sense_q) && $stable(even_q) && $stable(dbpre_q))); // R7
    AST_CKSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wipe_w) |=> $stable(cksel_q)); // R8
    AST_WIPE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_w |=> (!run_q && flag_q == '0)); // R9
    AST_OWNER_NS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_nonsec && !wipe_w) |=> $stable(owner_q)); // R10
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit_i) && !wipe_w) |=> ((flag_q & $past(hit_i)) == $past(hit_i))); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe_w |=> ((flag_q & $past(flag_q & ~clr_w)) == $past(flag_q & ~clr_w))); // R6
    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_q) |-> ((evt_q & ~$past(even_q)) == '0)); // R5
endmodule

// File: rtl/xint_ctrl.sv
// Top of the external interrupt line controller: NL general lines plus one
// non-maskable line, each with its own condition unit, and a register file.
// Assumes NL <= 8 so the packed sense word fits in 32 bits.
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pins_i,
    input  logic              nmi_pin_i,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_nonsec,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              nmi_req_o,
    output logic [NLINES-1:0] evt_o
);
    localparam int SW = NLINES * CFG_BITS;

    logic              run;
    logic [SW-1:0]     sense;
    logic [CFG_BITS-1:0] nmicfg;
    logic [NLINES:0]   hit;

    // One condition unit per general line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        xint_cond #(.SYNC_STAGES(2)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pins_i[g]),
            .run_i   (run),
            .sense_i (sense[g*CFG_BITS +: 3]),
            .filt_i  (sense[g*CFG_BITS + 3]),
            .hit_o   (hit[g])
        );
    end

    xint_cond #(.SYNC_STAGES(2)) u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (nmi_pin_i),
        .run_i   (run),
        .sense_i (nmicfg[2:0]),
        .filt_i  (nmicfg[3]),
        .hit_o   (hit[NLINES])
    );

    xint_regs #(.NL(NLINES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_nonsec (bus_nonsec),
        .bus_rdata  (bus_rdata),
        .hit_i      (hit),
        .run_o      (run),
        .sense_o    (sense),
        .nmicfg_o   (nmicfg),
        .irq_o      (irq_o),
        .nmi_req_o  (nmi_req_o),
        .evt_o      (evt_o)
    );
endmodule

// File: tb/sim_xint_ctrl.sv
module sim_xint_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = 8'b0010_0010;
    logic        nmi_pin = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic        bus_nonsec = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, nmi_req;
    logic [7:0]  evt;
    int          checks = 0, errors = 0, evcount = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    xint_ctrl #(.NLINES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .nmi_pin_i(nmi_pin),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_nonsec(bus_nonsec), .bus_rdata(bus_rdata),
        .irq_o(irq), .nmi_req_o(nmi_req), .evt_o(evt)
    );

    // Count event pulses on line 3, sampled away from the active edge.
    always @(negedge clk) if (evt[3]) evcount++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic ns);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_nonsec = ns;
        @(negedge clk);
        bus_wr = 1'b0; bus_nonsec = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic ns, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_nonsec = ns;
        #1 d = bus_rdata;
        bus_nonsec = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd(4'h0, 1'b0, rv); chk("R9 ctrl after reset", rv, 32'h0);
        rd(4'h3, 1'b0, rv); chk("R9 flags after reset", rv, 32'h0);
        chk("R3 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 nmi after reset", {31'b0, nmi_req}, 32'h0);
    endtask

    task automatic t_setup;
        wr(4'h5, 32'h0954_3121, 1'b0);
        wr(4'h4, 32'h08, 1'b0);
        wr(4'h2, 32'h7B, 1'b0);
        wr(4'h0, 32'h1, 1'b0);
        wait_cyc(8);
        wr(4'h3, 32'h1FF, 1'b0);
        rd(4'h3, 1'b0, rv); chk("R2 quiet after start", rv, 32'h0);
    endtask

    task automatic t_edges;
        @(negedge clk) pins[0] = 1'b1;
        wait_cyc(6);
        rd(4'h3, 1'b0, rv); chk("R2 rising edge flag", rv, 32'h01);
        chk("R3 irq unmasked line", {31'b0, irq}, 32'h1);
        wr(4'h3, 32'h01, 1'b0);
        @(negedge clk) pins[1] = 1'b0;
        wait_cyc(6);
        rd(4'h3, 1'b0, rv); chk("R2 falling edge flag", rv, 32'h02);
        wr(4'h3, 32'h02, 1'b0);
        @(negedge clk) pins[0] = 1'b0;
        wait_cyc(6);
        rd(4'h3, 1'b0, rv); chk("R2 no flag on falling of rise line", rv, 32'h0);
        chk("R3 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mask;
        @(negedge clk) pins[2] = 1'b1;
        wait_cyc(6);
        rd(4'h3, 1'b0, rv); chk("R3 masked line still flags", rv, 32'h04);
        chk("R3 masked line no irq", {31'b0, irq}, 32'h0);
        wr(4'h3, 32'h04, 1'b0);
    endtask

    task automatic t_both;
        evcount = 0;
        @(negedge clk) pins[3] = 1'b1;
        wait_cyc(6);
        @(negedge clk) pins[3] = 1'b0;
        wait_cyc(6);
        chk("R5 two events for one pulse", evcount, 32'd2);
        rd(4'h3, 1'b0, rv); chk("R2 both-edge flag", rv, 32'h08);
        wr(4'h3, 32'h08, 1'b0);
    endtask

    task automatic t_level;
        @(negedge clk) pins[4] = 1'b1;
        wait_cyc(6);
        wr(4'h3, 32'h10, 1'b0);
        wait_cyc(2);
        rd(4'h3, 1'b0, rv); chk("R6 high level refires after clear", rv, 32'h10);
        @(negedge clk) pins[4] = 1'b0;
        wait_cyc(6);
        wr(4'h3, 32'h10, 1'b0);
        rd(4'h3, 1'b0, rv); chk("R6 clear works after level gone", rv, 32'h0);
        @(negedge clk) pins[5] = 1'b0;
        wait_cyc(6);
        rd(4'h3, 1'b0, rv); chk("R2 low level flag", rv, 32'h20);
        @(negedge clk) pins[5] = 1'b1;
        wait_cyc(6);
        wr(4'h3, 32'h20, 1'b0);
    endtask

    task automatic t_filter;
        @(negedge clk) pins[6] = 1'b1;
        @(negedge clk) pins[6] = 1'b0;
        wait_cyc(8);
        rd(4'h3, 1'b0, rv); chk("R4 one-clock spike rejected", rv, 32'h0);
        @(negedge clk) pins[6] = 1'b1;
        wait_cyc(2);
        pins[6] = 1'b0;
        wait_cyc(8);
        rd(4'h3, 1'b0, rv); chk("R4 two-clock pulse accepted", rv, 32'h40);
        wr(4'h3, 32'h40, 1'b0);
        @(negedge clk) pins[7] = 1'b1;
        wait_cyc(6);
        rd(4'h3, 1'b0, rv); chk("R2 off line never flags", rv, 32'h0);
    endtask

    task automatic t_protect;
        wr(4'h5, 32'h0, 1'b0);
        rd(4'h5, 1'b0, rv); chk("R7 sense locked while running", rv, 32'h0954_3121);
        wr(4'h4, 32'hFF, 1'b0);
        rd(4'h4, 1'b0, rv); chk("R7 event enable locked", rv, 32'h08);
        wr(4'h0, 32'h4, 1'b0);
        rd(4'h0, 1'b0, rv); chk("R8 stop write keeps clock select", rv, 32'h0);
        wr(4'h4, 32'h0C, 1'b0);
        rd(4'h4, 1'b0, rv); chk("R7 write accepted while stopped", rv, 32'h0C);
        wr(4'h4, 32'h08, 1'b0);
        wr(4'h0, 32'h5, 1'b0);
        rd(4'h0, 1'b0, rv); chk("R8 start write sets clock select", rv, 32'h5);
        wr(4'h0, 32'h0, 1'b0);
        rd(4'h0, 1'b0, rv); chk("R8 stop keeps clock select", rv, 32'h4);
        wr(4'h0, 32'h1, 1'b0);
    endtask

    task automatic t_secure;
        wr(4'h9, 32'h01, 1'b0);
        wr(4'h2, 32'h00, 1'b1);
        rd(4'h2, 1'b0, rv); chk("R10 non-secure write spares secure line", rv, 32'h01);
        rd(4'h2, 1'b1, rv); chk("R10 secure bit hidden from non-secure", rv, 32'h00);
        @(negedge clk) pins[0] = 1'b1;
        wait_cyc(6);
        rd(4'h3, 1'b1, rv); chk("R10 secure flag hidden", rv, 32'h00);
        wr(4'h3, 32'h01, 1'b1);
        rd(4'h3, 1'b0, rv); chk("R10 non-secure clear dropped", rv, 32'h01);
        wr(4'h9, 32'h00, 1'b1);
        rd(4'h9, 1'b0, rv); chk("R10 ownership ignores non-secure", rv, 32'h01);
        wr(4'h3, 32'h01, 1'b0);
    endtask

    task automatic t_nmi;
        wr(4'h1, 32'h1, 1'b0);
        @(negedge clk) nmi_pin = 1'b1;
        wait_cyc(6);
        chk("R1 nmi request raised", {31'b0, nmi_req}, 32'h1);
        rd(4'h3, 1'b0, rv); chk("R1 nmi flag bit", rv, 32'h100);
        wr(4'h3, 32'h100, 1'b0);
        chk("R1 nmi cleared", {31'b0, nmi_req}, 32'h0);
    endtask

    task automatic t_wipe;
        wr(4'h0, 32'h2, 1'b0);
        rd(4'h0, 1'b0, rv); chk("R9 wipe stops controller", rv, 32'h0);
        rd(4'h5, 1'b0, rv); chk("R9 wipe clears sense", rv, 32'h0);
        rd(4'h2, 1'b0, rv); chk("R9 wipe clears mask", rv, 32'h0);
        rd(4'h9, 1'b0, rv); chk("R9 wipe clears ownership", rv, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_setup;
        t_edges;
        t_mask;
        t_both;
        t_level;
        t_filter;
        t_protect;
        t_secure;
        t_nmi;
        t_wipe;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule